// File: doc/BRIEF.md
# Four-Bank Synchronous DRAM Command Sequence Monitor

This block sits beside the command pins of a four-bank synchronous DRAM interface. It adds no traffic of its own. On every rising clock edge where the clock enable is high, it decodes the active-low chip-select, row-strobe, column-strobe and write-enable lines into a command. From those commands it keeps a model of each bank. A bank is either idle, open on a row, or closing while a precharge-to-activate timer runs.

When a command breaks the bank protocol, the monitor raises a one-cycle error pulse with a cause code. The protocol covers these cases:

- a command before the device has been given its first mode setting;
- a mode setting while a bank is busy;
- any command inside the short lockout that follows a mode setting;
- opening a bank that is already open;
- opening a bank before its precharge delay has elapsed.

A flagged command is discarded, so the model keeps tracking the real device. The bank states and the open row of every bank are visible on ports. Integration logic or a test environment can watch them.

Top module: `sdram_bank_monitor`

## Requirements
- R1: While the synchronous active-low reset is applied, and on the first edge after it, every bank state reads idle (code 00), every open row reads 0, the error pulse is low and the monitor counts as not yet configured.
- R2: A command is decoded only on an edge where cke is high and cs_n is low, using {ras_n,cas_n,we_n}: 000 mode set, 011 activate, 010 precharge, 111 no-operation. Any other pattern is an unmodelled command. cke low, cs_n high, no-operation and unmodelled commands outside a lockout change no state and raise no error.
- R3: Before the first accepted mode set after reset, every activate or precharge is flagged with cause 3 and discarded.
- R4: A mode set while any bank is not idle is flagged with cause 1 and discarded, and starts no lockout. With all banks idle, it is accepted and marks the monitor as configured.
- R5: On the two edges after an accepted mode set, any command other than no-operation or deselect is flagged with cause 2 and discarded.
- R6: An accepted activate moves the bank selected by ba from idle (00) to open (01) and latches addr[11:0] as that bank's open row.
- R7: An activate to a bank that is already open is flagged with cause 5, and the bank's open row stays unchanged.
- R8: A precharge with addr[10] low moves only the bank selected by ba from open to closing (10). A precharge of an idle bank is allowed: no error, and the bank stays idle.
- R9: A precharge with addr[10] high moves every open bank to closing, whatever the value on ba.
- R10: A bank that starts closing at edge N reads idle after edge N+PRE_TO_ACT-1. An activate to it at any edge from N+1 to N+PRE_TO_ACT-1 is flagged with cause 4 and discarded. An activate at edge N+PRE_TO_ACT is accepted.
- R11: err_valid is high for exactly the cycle after the offending edge, and err_code holds the cause there and 0 otherwise. The lockout cause outranks the not-configured cause, and that outranks all others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock, commands sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; commands are ignored while low |
| cs_n | input | 1 | Active-low chip select |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable |
| addr | input | 12 | Row address; bit 10 selects all-bank precharge |
| ba | input | 2 | Bank select |
| bank_state | output | 8 | Two bits per bank, bank b at [2b+1:2b]: 00 idle, 01 open, 10 closing |
| open_row | output | 48 | Twelve bits per bank, bank b at [12b+11:12b] |
| err_valid | output | 1 | One-cycle pulse for a flagged command |
| err_code | output | 3 | Cause of the flagged command, 0 when none |

## Verification
Activate is driven against a bank in each of its three states: idle, open and closing. This separates a plain open from the re-open fault and from the early-open fault, and a boundary activate exactly one delay after the precharge shows where the timer ends. Precharge is driven with the all-bank bit low and high while the bank select points at an idle bank, so a monitor that ignores the bit, or that honours ba on an all-bank precharge, gives a different state vector. Mode set is driven with banks busy and with banks idle, followed by commands in both lockout cycles and in the first free cycle, so a lockout that is too short, too long, or wrongly started by a refused mode set is visible. Commands with cke low, with cs_n high and before configuration show which gating layer is missing.

// File: rtl/sdram_mon_pkg.sv
// Shared types of the DRAM bank command monitor.
// Assumes: bank state codes are visible on ports and must stay fixed.
package sdram_mon_pkg;

    typedef enum logic [1:0] {
        BANK_IDLE   = 2'b00,
        BANK_OPEN   = 2'b01,
        BANK_CLOSING = 2'b10
    } bank_st_e;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_MODE  = 3'd1,
        CMD_OPEN  = 3'd2,
        CMD_CLOSE = 3'd3,
        CMD_OTHER = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_MODE_BUSY = 3'd1,
        CAUSE_LOCKOUT   = 3'd2,
        CAUSE_NOT_CFG   = 3'd3,
        CAUSE_EARLY_OPEN = 3'd4,
        CAUSE_REOPEN    = 3'd5
    } cause_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
// Turns the command strobes into a command kind.
// Assumes: the caller samples the result on the rising clock edge; purely combinational.
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Decode the strobes; cke low or cs_n high yields no command.
    always_comb begin
        if (!cke || cs_n) begin
            cmd = CMD_NONE;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MODE;
                3'b011:  cmd = CMD_OPEN;
                3'b010:  cmd = CMD_CLOSE;
                3'b111:  cmd = CMD_NONE;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/sdram_mode_guard.sv
// Tracks whether a mode setting has been accepted since reset and runs the
// lockout window that follows one.
// Assumes: mode_go is asserted only for an accepted mode setting; LOCK_CYC >= 1.
module sdram_mode_guard #(
    parameter int LOCK_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_go,
    output logic configured,
    output logic locked
);

    localparam int LCK_W = $clog2(LOCK_CYC + 1);

    logic [LCK_W-1:0] lock_cnt;

    // Set the configured flag and reload the lockout counter on a mode setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            configured <= 1'b0;
            lock_cnt   <= '0;
        end else if (mode_go) begin
            configured <= 1'b1;
            lock_cnt   <= LCK_W'(LOCK_CYC);
        end else if (lock_cnt != '0) begin
            lock_cnt   <= lock_cnt - LCK_W'(1);
        end
    end

    // The window is open while the counter is non-zero.
    always_comb locked = (lock_cnt != '0);

endmodule

// File: rtl/sdram_bank_fsm.sv
// State of one DRAM bank: idle, open on a row, or closing while a
// precharge-to-activate timer runs.
// Assumes: open_req only in the idle state; close_req in other states is ignored;
// PRE_TO_ACT >= 2 so that the closing state lasts at least one cycle.
module sdram_bank_fsm
    import sdram_mon_pkg::*;
#(
    parameter int ROW_W      = 12,
    parameter int PRE_TO_ACT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic [ROW_W-1:0] row_in,
    input  logic             close_req,
    output bank_st_e         state,
    output logic [ROW_W-1:0] row
);

    localparam int CNT_W = $clog2(PRE_TO_ACT + 1);

    logic [CNT_W-1:0] wait_cnt;

    // Step the bank through open, closing and back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= BANK_IDLE;
            row      <= '0;
            wait_cnt <= '0;
        end else begin
            case (state)
                BANK_IDLE: begin
                    if (open_req) begin
                        state <= BANK_OPEN;
                        row   <= row_in;
                    end
                end
                BANK_OPEN: begin
                    if (close_req) begin
                        state    <= BANK_CLOSING;
                        wait_cnt <= CNT_W'(PRE_TO_ACT - 1);
                    end
                end
                BANK_CLOSING: begin
                    if (wait_cnt <= CNT_W'(1)) begin
                        state    <= BANK_IDLE;
                        wait_cnt <= '0;
                    end else begin
                        wait_cnt <= wait_cnt - CNT_W'(1);
                    end
                end
                default: state <= BANK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_monitor.sv
// Watches a multi-bank synchronous DRAM command bus, models each bank and
// reports illegal command sequences with a one-cycle error pulse and cause.
// Assumes: a single command per rising edge; flagged commands are treated as
// discarded by the device; read, write and refresh are not modelled.
module sdram_bank_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int ROW_W        = 12,
    parameter int ALL_BANK_BIT = 10,
    parameter int PRE_TO_ACT   = 3,
    parameter int MODE_LOCK    = 2,
    localparam int BA_W        = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [ROW_W-1:0]           addr,
    input  logic [BA_W-1:0]            ba,
    output logic [2*NUM_BANKS-1:0]     bank_state,
    output logic [ROW_W*NUM_BANKS-1:0] open_row,
    output logic                       err_valid,
    output logic [2:0]                 err_code
);

    cmd_e             cmd;
    cause_e           cause;
    logic             mode_go;
    logic             open_go;
    logic             close_go;
    logic             configured;
    logic             locked;
    logic             all_idle;
    bank_st_e         st   [NUM_BANKS];
    logic [ROW_W-1:0] rows [NUM_BANKS];

    sdram_cmd_decode u_decode (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdram_mode_guard #(
        .LOCK_CYC (MODE_LOCK)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_go    (mode_go),
        .configured (configured),
        .locked     (locked)
    );

    // Reduce the bank states to a single all-idle flag.
    always_comb begin
        all_idle = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (st[b] != BANK_IDLE) all_idle = 1'b0;
        end
    end

    // Judge the sampled command and choose its cause; highest priority first.
    always_comb begin
        cause    = CAUSE_NONE;
        mode_go  = 1'b0;
        open_go  = 1'b0;
        close_go = 1'b0;
        if (cmd != CMD_NONE) begin
            if (locked) begin
                cause = CAUSE_LOCKOUT;
            end else begin
                case (cmd)
                    CMD_MODE: begin
                        if (!all_idle) cause = CAUSE_MODE_BUSY;
                        else           mode_go = 1'b1;
                    end
                    CMD_OPEN: begin
                        if (!configured)                  cause = CAUSE_NOT_CFG;
                        else if (st[ba] == BANK_OPEN)     cause = CAUSE_REOPEN;
                        else if (st[ba] == BANK_CLOSING)  cause = CAUSE_EARLY_OPEN;
                        else                              open_go = 1'b1;
                    end
                    CMD_CLOSE: begin
                        if (!configured) cause = CAUSE_NOT_CFG;
                        else             close_go = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic open_sel;
            logic close_sel;

            // Route the accepted command to this bank.
            always_comb begin
                open_sel  = open_go && (ba == BA_W'(b));
                close_sel = close_go && (addr[ALL_BANK_BIT] || (ba == BA_W'(b)));
            end

            sdram_bank_fsm #(
                .ROW_W      (ROW_W),
                .PRE_TO_ACT (PRE_TO_ACT)
            ) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .open_req  (open_sel),
                .row_in    (addr),
                .close_req (close_sel),
                .state     (st[b]),
                .row       (rows[b])
            );

            // Flatten the bank view onto the output buses.
            always_comb begin
                bank_state[2*b +: 2]         = st[b];
                open_row[ROW_W*b +: ROW_W]   = rows[b];
            end
        end
    endgenerate

    // Register the error pulse and its cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_code  <= 3'd0;
        end else begin
            err_valid <= (cause != CAUSE_NONE);
            err_code  <= cause;
        end
    end

endmodule

// File: rtl/sdram_bank_monitor_chk.sv
// Property checker for the bank monitor, attached by bind.
// Assumes: bank state codes 00 idle, 01 open, 10 closing.
module sdram_bank_monitor_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cke,
    input logic                       cs_n,
    input logic                       ras_n,
    input logic                       cas_n,
    input logic                       we_n,
    input logic [ROW_W-1:0]           addr,
    input logic [BA_W-1:0]            ba,
    input logic [2*NUM_BANKS-1:0]     bank_state,
    input logic [ROW_W*NUM_BANKS-1:0] open_row,
    input logic                       err_valid,
    input logic [2:0]                 err_code
);

    logic mode_cmd;
    logic live_cmd;
    logic unused_ok;

    always_comb begin
        mode_cmd  = cke && !cs_n && !ras_n && !cas_n && !we_n;
        live_cmd  = cke && !cs_n && !(ras_n && cas_n && we_n);
        unused_ok = ^{addr, ba};
    end

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (bank_state == '0 && open_row == '0 && !err_valid)); // R1

    AST_CODE_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_code != 3'd0)); // R11

    AST_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> (err_code == 3'd0)); // R11

    AST_LOCKOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_cmd) && !err_valid && live_cmd)
        |=> (err_valid && err_code == 3'd2)); // R5

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
            AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                (bank_state[2*b +: 2] == 2'b01) ##1 (bank_state[2*b +: 2] == 2'b01)
                |-> $stable(open_row[ROW_W*b +: ROW_W])); // R7

            AST_NO_DIRECT_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
                (bank_state[2*b +: 2] == 2'b10) |=> (bank_state[2*b +: 2] != 2'b01)); // R10

            AST_IDLE_NOT_CLOSING: assert property (@(posedge clk) disable iff (!rst_n)
                (bank_state[2*b +: 2] == 2'b00) |=> (bank_state[2*b +: 2] != 2'b10)); // R8

            AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
                bank_state[2*b +: 2] != 2'b11); // R6
        end
    endgenerate

    AST_INPUTS_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(unused_ok) || !cke); // R2

endmodule

bind sdram_bank_monitor sdram_bank_monitor_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .addr       (addr),
    .ba         (ba),
    .bank_state (bank_state),
    .open_row   (open_row),
    .err_valid  (err_valid),
    .err_code   (err_code)
);

// File: tb/sdram_bank_monitor_bench.sv
// Directed bench for the bank monitor: one task per scenario.
module sdram_bank_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [3:0] C_NOP  = 4'b0111;
    localparam logic [3:0] C_DES  = 4'b1111;
    localparam logic [3:0] C_MODE = 4'b0000;
    localparam logic [3:0] C_OPEN = 4'b0011;
    localparam logic [3:0] C_CLOSE = 4'b0010;
    localparam logic [3:0] C_READ = 4'b0101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [1:0]  ba = '0;
    logic [7:0]  bank_state;
    logic [47:0] open_row;
    logic        err_valid;
    logic [2:0]  err_code;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    sdram_bank_monitor u_sdram_bank_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .addr       (addr),
        .ba         (ba),
        .bank_state (bank_state),
        .open_row   (open_row),
        .err_valid  (err_valid),
        .err_code   (err_code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one command at a falling edge; return after the next falling edge
    // with the bus back at no-operation, so results of that edge can be read.
    task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a,
                         input logic en = 1'b1);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba   = b;
        addr = a;
        cke  = en;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        cke  = 1'b1;
    endtask

    function automatic logic [11:0] row_of(input int b);
        return open_row[12*b +: 12];
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 states", bank_state, 8'h00);
        check("R1 rows", open_row, 48'h0);
        check("R1 err", err_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 states after release", bank_state, 8'h00);
    endtask

    task automatic t_not_configured();
        issue(C_OPEN, 2'd1, 12'h005);
        check("R3 open before config err", {err_valid, err_code}, {1'b1, 3'd3});
        check("R3 open before config state", bank_state, 8'h00);
        issue(C_CLOSE, 2'd0, 12'h400);
        check("R3 close before config", {err_valid, err_code}, {1'b1, 3'd3});
        issue(C_NOP, 2'd0, 12'h000);
        check("R11 pulse drops", {err_valid, err_code}, {1'b0, 3'd0});
    endtask

    task automatic t_gating();
        issue(C_OPEN, 2'd1, 12'h005, 1'b0);
        check("R2 cke low ignored", {err_valid, bank_state}, 9'h000);
        issue(C_MODE, 2'd0, 12'h000, 1'b0);
        issue(C_OPEN, 2'd1, 12'h005);
        check("R2 cke low mode ignored", {err_valid, err_code}, {1'b1, 3'd3});
        issue(C_DES & 4'b1000 | C_OPEN | 4'b1000, 2'd1, 12'h005);
        check("R2 deselect ignored", {err_valid, bank_state}, 9'h000);
        issue(C_READ, 2'd1, 12'h005);
        check("R2 other command ignored", {err_valid, bank_state}, 9'h000);
    endtask

    task automatic t_configure();
        issue(C_MODE, 2'd0, 12'h000);
        check("R4 mode accepted idle", err_valid, 1'b0);
        issue(C_OPEN, 2'd0, 12'h123);
        check("R5 lockout first cycle", {err_valid, err_code}, {1'b1, 3'd2});
        check("R5 lockout discards", bank_state, 8'h00);
        issue(C_CLOSE, 2'd0, 12'h000);
        check("R5 lockout second cycle", {err_valid, err_code}, {1'b1, 3'd2});
        issue(C_OPEN, 2'd0, 12'h123);
        check("R5 lockout over", err_valid, 1'b0);
        check("R6 bank0 open", bank_state, 8'h01);
        check("R6 bank0 row", row_of(0), 12'h123);
    endtask

    task automatic t_reopen();
        issue(C_OPEN, 2'd0, 12'h456);
        check("R7 reopen flagged", {err_valid, err_code}, {1'b1, 3'd5});
        check("R7 row kept", row_of(0), 12'h123);
    endtask

    task automatic t_mode_busy();
        issue(C_MODE, 2'd0, 12'h000);
        check("R4 mode busy", {err_valid, err_code}, {1'b1, 3'd1});
        issue(C_OPEN, 2'd2, 12'h0AB);
        check("R4 no lockout after refusal", err_valid, 1'b0);
        check("R6 bank2 open", bank_state, 8'h11);
        check("R6 bank2 row", row_of(2), 12'h0AB);
    endtask

    task automatic t_close_single();
        issue(C_CLOSE, 2'd2, 12'h000);
        check("R8 single close", {err_valid, bank_state}, {1'b0, 8'h21});
        issue(C_OPEN, 2'd2, 12'h7FF);
        check("R10 early open", {err_valid, err_code}, {1'b1, 3'd4});
        check("R10 still closing", bank_state, 8'h21);
        issue(C_NOP, 2'd0, 12'h000);
        check("R10 idle after delay", bank_state, 8'h01);
        issue(C_OPEN, 2'd2, 12'h7FF);
        check("R10 open at boundary", {err_valid, bank_state}, {1'b0, 8'h11});
        check("R10 new row", row_of(2), 12'h7FF);
        issue(C_CLOSE, 2'd3, 12'h000);
        check("R8 idle close allowed", {err_valid, bank_state}, {1'b0, 8'h11});
    endtask

    task automatic t_close_all();
        issue(C_CLOSE, 2'd1, 12'h400);
        check("R9 all-bank close", {err_valid, bank_state}, {1'b0, 8'h22});
        issue(C_NOP, 2'd0, 12'h000);
        issue(C_NOP, 2'd0, 12'h000);
        check("R9 all idle", bank_state, 8'h00);
        issue(C_MODE, 2'd0, 12'h000);
        check("R4 mode after all idle", err_valid, 1'b0);
        issue(C_NOP, 2'd0, 12'h000);
        issue(C_NOP, 2'd0, 12'h000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_not_configured();
        t_gating();
        t_configure();
        t_reopen();
        t_mode_busy();
        t_close_single();
        t_close_all();
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule